// File: doc/BRIEF.md
# Dual-Read Register File with Zero Register

This block is the integer register storage of a load/store datapath that uses three-address instructions. It holds 32 words of 32 bits. Two read ports, each with its own 5-bit address, return their selected words at the same time, so one ALU operation can fetch both of its sources in one cycle. A single write port stores a word on the rising clock edge when its enable is high.

Entry 0 is wired to zero. Reads of entry 0 always return zero, and writes to it are dropped without any effect. Paired with an add-immediate operation, this gives a cheap way to load a constant. Reads are combinational from the current addresses. A read that targets the entry being written in the same cycle sees the old contents until the edge, because there is no bypass path. A synchronous, active-high reset clears every entry.

Top module: `dual_rd_regfile`

## Requirements
- R1: A word written to entry k (k from 1 to 31) with `wr_en`=1 is returned by read port A addressed to k after the next rising edge.
- R2: Read ports A and B work independently. In the same cycle, each returns the entry selected by its own address, including when the two addresses differ or are equal.
- R3: Read data is combinational. Changing a read address changes that port's data within the same cycle, with no clock edge.
- R4: When `wr_en`=0 at a rising edge, no entry changes, whatever `wr_addr` and `wr_data` hold.
- R5: Entry 0 reads as 32'h0 on both ports at all times. A write with `wr_addr`=0 has no effect on any entry.
- R6: When a read address equals `wr_addr` while `wr_en`=1, the read returns the old contents until the rising edge and the new word after it.
- R7: Reset is synchronous and active high. Raising `rst` between edges leaves all contents visible unchanged; after one rising edge with `rst`=1, every entry reads zero.
- R8: A write changes only the addressed entry. All other entries keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high clear of all entries |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Entry to be written |
| wr_data | input | 32 | Word to be written |
| rd_a_addr | input | 5 | Read port A entry select |
| rd_a_data | output | 32 | Read port A data, combinational |
| rd_b_addr | input | 5 | Read port B entry select |
| rd_b_data | output | 32 | Read port B data, combinational |

## Verification
The bench writes a nonzero pattern to entry 0 and reads it back on both ports. A file that stored it would return that pattern instead of zero. It reads an entry during the same cycle it is written: a design that bypasses the write data would show the new word one edge early, and a design that registers its reads would show it one edge late. It raises reset between edges and checks that the contents are still visible, which catches an asynchronous clear. It also runs a stream of pseudo-random writes, some with the enable low and some aimed at entry 0, against a reference array. This exposes decode faults that would corrupt entries next to the one being written.

// File: rtl/rf_pkg.sv
package rf_pkg;
    parameter int RF_ADDR_W = 5;
    parameter int RF_DATA_W = 32;
endpackage

// File: rtl/rf_write_decode.sv
// Turns the write port into a one-hot entry select; entry 0 never selected.
module rf_write_decode #(
    parameter int ADDR_W = rf_pkg::RF_ADDR_W,
    localparam int NREG = 1 << ADDR_W
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [NREG-1:0]   wr_sel
);
    always_comb begin
        wr_sel = '0;
        if (wr_en) begin
            wr_sel[wr_addr] = 1'b1;
        end
        wr_sel[0] = 1'b0;
    end
endmodule

// File: rtl/rf_storage.sv
// Entry flops; entry 0 is a constant and has no storage.
module rf_storage #(
    parameter int ADDR_W = rf_pkg::RF_ADDR_W,
    parameter int DATA_W = rf_pkg::RF_DATA_W,
    localparam int NREG = 1 << ADDR_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NREG-1:0]              wr_sel,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [NREG-1:0][DATA_W-1:0]  entries
);
    for (genvar g = 0; g < NREG; g++) begin : g_entry
        if (g == 0) begin : g_zero
            assign entries[g] = '0;
        end else begin : g_flop
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (wr_sel[g]) begin
                    q <= wr_data;
                end
            end
            assign entries[g] = q;
        end
    end
endmodule

// File: rtl/rf_read_mux.sv
// One combinational read port.
module rf_read_mux #(
    parameter int ADDR_W = rf_pkg::RF_ADDR_W,
    parameter int DATA_W = rf_pkg::RF_DATA_W,
    localparam int NREG = 1 << ADDR_W
) (
    input  logic [NREG-1:0][DATA_W-1:0] entries,
    input  logic [ADDR_W-1:0]           sel,
    output logic [DATA_W-1:0]           data
);
    always_comb begin
        data = entries[sel];
    end
endmodule

// File: rtl/dual_rd_regfile.sv
module dual_rd_regfile #(
    parameter int ADDR_W = rf_pkg::RF_ADDR_W,
    parameter int DATA_W = rf_pkg::RF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_a_addr,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [ADDR_W-1:0] rd_b_addr,
    output logic [DATA_W-1:0] rd_b_data
);
    localparam int NREG = 1 << ADDR_W;
    localparam int NPORT = 2;

    logic [NREG-1:0]             wr_sel;
    logic [NREG-1:0][DATA_W-1:0] entries;
    logic [NPORT-1:0][ADDR_W-1:0] rd_sel;
    logic [NPORT-1:0][DATA_W-1:0] rd_out;

    rf_write_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_sel  (wr_sel)
    );

    rf_storage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .entries (entries)
    );

    assign rd_sel[0] = rd_a_addr;
    assign rd_sel[1] = rd_b_addr;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        rf_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
            .entries (entries),
            .sel     (rd_sel[p]),
            .data    (rd_out[p])
        );
    end

    assign rd_a_data = rd_out[0];
    assign rd_b_data = rd_out[1];
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
    parameter int ADDR_W = rf_pkg::RF_ADDR_W,
    parameter int DATA_W = rf_pkg::RF_DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_a_addr,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [ADDR_W-1:0] rd_b_addr,
    input logic [DATA_W-1:0] rd_b_data
);
    assert_write_lands_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != '0) |=>
            ((rd_a_addr != $past(wr_addr)) || (rd_a_data == $past(wr_data))));

    assert_zero_port_a_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_a_addr == '0) |-> (rd_a_data == '0));

    assert_zero_port_b_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_b_addr == '0) |-> (rd_b_data == '0));

    assert_hold_unwritten_R8: assert property (@(posedge clk) disable iff (rst)
        (!wr_en || wr_addr != rd_b_addr) |=>
            ((rd_b_addr != $past(rd_b_addr)) || $stable(rd_b_data)));

    assert_same_addr_match_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_a_addr == rd_b_addr) |-> (rd_a_data == rd_b_data));

    assert_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_a_data == '0 && rd_b_data == '0));
endmodule

bind dual_rd_regfile rf_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_a_addr (rd_a_addr),
    .rd_a_data (rd_a_data),
    .rd_b_addr (rd_b_addr),
    .rd_b_data (rd_b_data)
);

// File: tb/sim_dual_rd_regfile.sv
`timescale 1ns/1ps
module sim_dual_rd_regfile;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_a_addr = '0;
    logic [31:0] rd_a_data;
    logic [4:0]  rd_b_addr = '0;
    logic [31:0] rd_b_data;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;
    logic [31:0] model [32];
    logic [31:0] lfsr = 32'h1234_5678;

    always #2.5 clk = ~clk;

    dual_rd_regfile u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand();
        lfsr = lfsr * 32'd1664525 + 32'd1013904223;
        return lfsr;
    endfunction

    // Drives at a falling edge, returns at the following falling edge.
    task automatic write_word(input logic [4:0] a, input logic [31:0] d, input logic en);
        wr_en = en; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (en && a != 5'd0) model[a] = d;
    endtask

    task automatic scan_all(input string tag);
        for (int i = 0; i < 32; i++) begin
            rd_a_addr = 5'(i); rd_b_addr = 5'(31 - i);
            #0.5;
            chk({tag, " portA"}, rd_a_data, model[i]);
            chk({tag, " portB"}, rd_b_data, model[31 - i]);
        end
    endtask

    task automatic t_reset_state();
        for (int i = 0; i < 32; i++) model[i] = '0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        scan_all("R7 reset state");
    endtask

    task automatic t_basic();
        write_word(5'd3, 32'hDEAD_BEEF, 1'b1);
        rd_a_addr = 5'd3; #0.5;
        chk("R1 write then read A", rd_a_data, 32'hDEAD_BEEF);
        write_word(5'd31, 32'hA5A5_0F0F, 1'b1);
        rd_a_addr = 5'd31; #0.5;
        chk("R1 top entry", rd_a_data, 32'hA5A5_0F0F);
    endtask

    task automatic t_two_ports();
        write_word(5'd10, 32'h1111_0000, 1'b1);
        write_word(5'd11, 32'h0000_2222, 1'b1);
        rd_a_addr = 5'd10; rd_b_addr = 5'd11; #0.5;
        chk("R2 A distinct", rd_a_data, 32'h1111_0000);
        chk("R2 B distinct", rd_b_data, 32'h0000_2222);
        rd_b_addr = 5'd10; #0.5;
        chk("R2 B same as A", rd_b_data, 32'h1111_0000);
    endtask

    task automatic t_comb_read();
        rd_a_addr = 5'd11; #0.5;
        chk("R3 comb read 1", rd_a_data, 32'h0000_2222);
        rd_a_addr = 5'd3; #0.5;
        chk("R3 comb read 2 no edge", rd_a_data, 32'hDEAD_BEEF);
    endtask

    task automatic t_enable_low();
        write_word(5'd3, 32'hFFFF_FFFF, 1'b0);
        rd_a_addr = 5'd3; #0.5;
        chk("R4 enable low ignored", rd_a_data, 32'hDEAD_BEEF);
    endtask

    task automatic t_zero_reg();
        write_word(5'd0, 32'hCAFE_F00D, 1'b1);
        rd_a_addr = 5'd0; rd_b_addr = 5'd0; #0.5;
        chk("R5 zero reg A", rd_a_data, 32'h0);
        chk("R5 zero reg B", rd_b_data, 32'h0);
        scan_all("R5 zero write no side effect");
    endtask

    task automatic t_read_during_write();
        rd_a_addr = 5'd7; rd_b_addr = 5'd7;
        wr_en = 1'b1; wr_addr = 5'd7; wr_data = 32'h7777_7777;
        #0.5;
        chk("R6 old before edge A", rd_a_data, model[7]);
        chk("R6 old before edge B", rd_b_data, model[7]);
        @(negedge clk);
        wr_en = 1'b0; model[7] = 32'h7777_7777;
        #0.5;
        chk("R6 new after edge", rd_a_data, 32'h7777_7777);
    endtask

    task automatic t_random();
        for (int n = 0; n < 300; n++) begin
            logic [31:0] r;
            r = next_rand();
            write_word(r[4:0], next_rand(), r[9:8] != 2'b00);
            rd_a_addr = r[14:10]; rd_b_addr = r[19:15]; #0.5;
            chk("R8 random A", rd_a_data, model[r[14:10]]);
            chk("R8 random B", rd_b_data, model[r[19:15]]);
        end
        scan_all("R8 final sweep");
    endtask

    task automatic t_sync_reset();
        write_word(5'd5, 32'h5555_AAAA, 1'b1);
        rd_a_addr = 5'd5;
        rst = 1'b1; #0.5;
        chk("R7 no clear before edge", rd_a_data, 32'h5555_AAAA);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 32; i++) model[i] = '0;
        scan_all("R7 cleared after edge");
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_basic();
        t_two_ports();
        t_comb_read();
        t_enable_low();
        t_zero_reg();
        t_read_during_write();
        t_random();
        t_sync_reset();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule